// File: doc/BRIEF.md
# Dual-Mode Instruction Length and Bundle Decoder

This block sits behind the instruction fetch buffer of a core that runs either a native instruction set or a RISC-V compatible one. Each ISA can run in a sequential mode or a wide-execute mode. A two-bit mode value picks how a 64-bit fetch window is cut into instructions. For each instruction slot in the window, the block reports whether the slot is valid, whether it holds a 16-bit or a 32-bit instruction, and whether it closes an issue bundle. It also flags reserved encodings, misaligned wide-execute fetches and bundles that grow too wide. All results are registered, so they appear one cycle after the fetch.

The mode is held in the block. Bit 0 of the mode selects the ISA (1 = RISC-V) and bit 1 selects wide-execute. A status-register write loads the mode directly. A branch redirect whose target has bit 0 set flips the ISA bit, and the cleaned target becomes the next fetch address. A redirect or a mode write discards any fetch presented in the same cycle. It also throws away the bundle that was being built, so the new mode applies from the first fetch after it. In sequential modes every instruction stands alone. In wide-execute modes the low two bits of each 32-bit op say whether the op issues together with the op that follows it.

Top module: `dmi_dec`

## Requirements
- R1: After reset the mode is 00 (native sequential). The output valid, all slot flags, both fault flags and the next fetch address are zero.
- R2: In RISC-V scalar mode (mode 01), an instruction whose first halfword has low bits 11 is 32 bits long. Any other low bits mean 16 bits, and longer formats are never recognised. Slots are packed from halfword 0 upward, and a 32-bit op starting in the last halfword is left for the next fetch.
- R3: In the sequential modes (mode bit 1 = 0), every valid slot is marked end-of-bundle and no fault flag is raised.
- R4: In RISC-V wide-execute mode (mode 11), every op is 32 bits at halfwords 0 and 2. Low bits 10 mark an op that continues the bundle (end flag 0), and low bits 11 mark an op that ends it (end flag 1).
- R5: In RISC-V wide-execute mode, low bits 00 or 01 set the slot's illegal flag. Such a slot is still reported as a 32-bit op that ends the bundle.
- R6: In RISC-V wide-execute mode, a fetch address with bit 1 set raises the alignment fault. No slot is valid, and the next fetch address equals the faulting address.
- R7: A bundle holds at most MAX_BUNDLE ops, even across fetch windows. An op marked continue at position MAX_BUNDLE is forced to end the bundle and raises the overflow flag.
- R8: A redirect whose target has bit 0 set flips mode bit 0. The next fetch address becomes the target with bit 0 cleared. A fetch in the same cycle is dropped, and the open bundle is discarded.
- R9: A mode write loads the mode in the next cycle, drops a fetch in the same cycle, clears the open bundle, and overrides a same-cycle redirect toggle.
- R10: Results appear exactly one cycle after the fetch and last one cycle. The next fetch address is the fetch address plus twice the number of halfwords consumed, and it holds while no fetch or redirect arrives.
- R11: In native modes every op is 32 bits. In native wide-execute mode (mode 10), low bits 10 continue the bundle and all other values end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_fetch_vld | input | 1 | Fetch window present |
| i_fetch_addr | input | AW | Byte address of window halfword 0 |
| i_fetch_win | input | WIN_W | Fetch window, halfword k at bits 16k+15:16k |
| i_redir | input | 1 | Branch redirect |
| i_redir_tgt | input | AW | Redirect target, bit 0 = ISA toggle |
| i_sr_wr | input | 1 | Mode field write |
| i_sr_mode | input | 2 | Mode value to load |
| o_mode | output | 2 | Current mode |
| o_vld | output | 1 | Decoded result valid |
| o_slot_vld | output | NSLOT | Slot holds an instruction |
| o_slot_len32 | output | NSLOT | Slot is 32-bit (else 16-bit) |
| o_slot_eob | output | NSLOT | Slot ends its bundle |
| o_slot_ill | output | NSLOT | Slot uses a reserved encoding |
| o_align_flt | output | 1 | Misaligned wide-execute fetch |
| o_ovf_flt | output | 1 | Bundle width limit hit |
| o_next_addr | output | AW | Next fetch address |

## Verification
The bench uses the default parameters: 32-bit addresses, a 64-bit window (four halfword slots) and a bundle limit of three. With only two wide-execute ops per window and a limit of three, a bundle must span fetches before it can overflow. This lets the bench check both that the bundle count is carried across windows and that a redirect clears it. The four-halfword window also exposes a 32-bit op that starts in the last halfword, and fully packed 16-bit windows.

// File: rtl/dmi_pkg.sv
package dmi_pkg;

    typedef enum logic [1:0] {
        MODE_NAT_SEQ   = 2'b00,
        MODE_RV_SCALAR = 2'b01,
        MODE_NAT_WIDE  = 2'b10,
        MODE_RV_WIDE   = 2'b11
    } dmi_mode_e;

    typedef struct packed {
        logic vld;
        logic len32;
        logic eob;
        logic ill;
    } dmi_slot_t;

    typedef struct packed {
        logic len32;
        logic cont;
        logic rsvd;
    } dmi_cls_t;

    function automatic logic mode_is_rv(input dmi_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_is_wide(input dmi_mode_e m);
        return m[1];
    endfunction

    // Classify one instruction from the two low bits of its first halfword.
    function automatic dmi_cls_t classify(input dmi_mode_e m, input logic [1:0] lo);
        dmi_cls_t c;
        c.len32 = 1'b1;
        c.cont  = 1'b0;
        c.rsvd  = 1'b0;
        unique case (m)
            MODE_RV_SCALAR: c.len32 = (lo == 2'b11);
            MODE_RV_WIDE: begin
                c.cont = (lo == 2'b10);
                c.rsvd = ~lo[1];
            end
            MODE_NAT_WIDE:  c.cont = (lo == 2'b10);
            default:        c.cont = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dmi_mode_reg.sv
module dmi_mode_reg
    import dmi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      i_redir,
    input  logic      i_redir_bit0,
    input  logic      i_sr_wr,
    input  logic [1:0] i_sr_mode,
    output dmi_mode_e o_mode,
    output logic      o_flush
);
    dmi_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_NAT_SEQ;
        end else if (i_sr_wr) begin
            mode_q <= dmi_mode_e'(i_sr_mode);
        end else if (i_redir && i_redir_bit0) begin
            mode_q <= dmi_mode_e'({mode_q[1], ~mode_q[0]});
        end
    end

    assign o_mode  = mode_q;
    assign o_flush = i_redir | i_sr_wr;
endmodule

// File: rtl/dmi_slot_walk.sv
module dmi_slot_walk
    import dmi_pkg::*;
#(
    parameter int WIN_W      = 64,
    parameter int MAX_BUNDLE = 3,
    localparam int NSLOT     = WIN_W / 16,
    localparam int HW_W      = $clog2(NSLOT + 1),
    localparam int CNT_W     = $clog2(MAX_BUNDLE + 1)
) (
    input  dmi_mode_e                   i_mode,
    input  logic [WIN_W-1:0]            i_win,
    input  logic                        i_addr_b1,
    input  logic [CNT_W-1:0]            i_cnt,
    output dmi_slot_t [NSLOT-1:0]       o_slots,
    output logic [CNT_W-1:0]            o_cnt,
    output logic [HW_W-1:0]             o_hw_used,
    output logic                        o_align_flt,
    output logic                        o_ovf
);
    localparam logic [HW_W-1:0]  POS_END  = HW_W'(NSLOT);
    localparam logic [HW_W-1:0]  POS_LAST = HW_W'(NSLOT - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_BUNDLE - 1);

    logic [HW_W-1:0]  pos;
    logic [CNT_W-1:0] cnt;
    logic             stop;
    logic [1:0]       lo;
    dmi_cls_t         cl;
    logic             win_unused;

    assign win_unused = ^i_win;

    always_comb begin
        o_slots     = '0;
        o_ovf       = 1'b0;
        o_align_flt = 1'b0;
        cnt         = i_cnt;
        pos         = '0;
        stop        = 1'b0;
        lo          = 2'b00;
        cl          = '0;
        if (mode_is_rv(i_mode) && mode_is_wide(i_mode) && i_addr_b1) begin
            o_align_flt = 1'b1;
            stop        = 1'b1;
        end
        for (int k = 0; k < NSLOT; k++) begin
            if (!stop && (pos < POS_END)) begin
                lo = i_win[{pos, 4'b0000} +: 2];
                cl = classify(i_mode, lo);
                if (cl.len32 && (pos == POS_LAST)) begin
                    stop = 1'b1;
                end else begin
                    o_slots[k].vld   = 1'b1;
                    o_slots[k].len32 = cl.len32;
                    o_slots[k].ill   = cl.rsvd;
                    if (!mode_is_wide(i_mode) || !cl.cont) begin
                        o_slots[k].eob = 1'b1;
                        cnt            = '0;
                    end else if (cnt == CNT_LAST) begin
                        o_slots[k].eob = 1'b1;
                        o_ovf          = 1'b1;
                        cnt            = '0;
                    end else begin
                        o_slots[k].eob = 1'b0;
                        cnt            = cnt + 1'b1;
                    end
                    pos = pos + (cl.len32 ? HW_W'(2) : HW_W'(1));
                end
            end
        end
        o_cnt     = cnt;
        o_hw_used = pos;
    end
endmodule

// File: rtl/dmi_dec.sv
module dmi_dec
    import dmi_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WIN_W      = 64,
    parameter int MAX_BUNDLE = 3,
    localparam int NSLOT     = WIN_W / 16,
    localparam int HW_W      = $clog2(NSLOT + 1),
    localparam int CNT_W     = $clog2(MAX_BUNDLE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_fetch_vld,
    input  logic [AW-1:0]    i_fetch_addr,
    input  logic [WIN_W-1:0] i_fetch_win,
    input  logic             i_redir,
    input  logic [AW-1:0]    i_redir_tgt,
    input  logic             i_sr_wr,
    input  logic [1:0]       i_sr_mode,
    output logic [1:0]       o_mode,
    output logic             o_vld,
    output logic [NSLOT-1:0] o_slot_vld,
    output logic [NSLOT-1:0] o_slot_len32,
    output logic [NSLOT-1:0] o_slot_eob,
    output logic [NSLOT-1:0] o_slot_ill,
    output logic             o_align_flt,
    output logic             o_ovf_flt,
    output logic [AW-1:0]    o_next_addr
);
    dmi_mode_e             mode;
    logic                  flush;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    dmi_slot_t [NSLOT-1:0] slots_d, slots_q;
    logic [HW_W-1:0]       hw_used;
    logic                  align_d, ovf_d;
    logic                  take;

    dmi_mode_reg u_mode (
        .clk         (clk),
        .rst         (rst),
        .i_redir     (i_redir),
        .i_redir_bit0(i_redir_tgt[0]),
        .i_sr_wr     (i_sr_wr),
        .i_sr_mode   (i_sr_mode),
        .o_mode      (mode),
        .o_flush     (flush)
    );

    dmi_slot_walk #(
        .WIN_W     (WIN_W),
        .MAX_BUNDLE(MAX_BUNDLE)
    ) u_walk (
        .i_mode     (mode),
        .i_win      (i_fetch_win),
        .i_addr_b1  (i_fetch_addr[1]),
        .i_cnt      (cnt_q),
        .o_slots    (slots_d),
        .o_cnt      (cnt_d),
        .o_hw_used  (hw_used),
        .o_align_flt(align_d),
        .o_ovf      (ovf_d)
    );

    assign take = i_fetch_vld && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            slots_q     <= '0;
            o_vld       <= 1'b0;
            o_align_flt <= 1'b0;
            o_ovf_flt   <= 1'b0;
            o_next_addr <= '0;
        end else begin
            o_vld <= take;
            if (take) begin
                cnt_q       <= cnt_d;
                slots_q     <= slots_d;
                o_align_flt <= align_d;
                o_ovf_flt   <= ovf_d;
                o_next_addr <= i_fetch_addr + AW'({hw_used, 1'b0});
            end else begin
                slots_q     <= '0;
                o_align_flt <= 1'b0;
                o_ovf_flt   <= 1'b0;
                if (flush) begin
                    cnt_q <= '0;
                end
                if (i_redir) begin
                    o_next_addr <= {i_redir_tgt[AW-1:1], 1'b0};
                end
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign o_slot_vld[g]   = slots_q[g].vld;
        assign o_slot_len32[g] = slots_q[g].len32;
        assign o_slot_eob[g]   = slots_q[g].eob;
        assign o_slot_ill[g]   = slots_q[g].ill;
    end

    assign o_mode = mode;
endmodule

// File: rtl/dmi_dec_chk.sv
module dmi_dec_chk #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             i_redir,
    input logic             i_redir_bit0,
    input logic             i_sr_wr,
    input logic [1:0]       i_sr_mode,
    input logic [1:0]       o_mode,
    input logic             o_vld,
    input logic [NSLOT-1:0] o_slot_vld,
    input logic [NSLOT-1:0] o_slot_eob,
    input logic [NSLOT-1:0] o_slot_ill,
    input logic             o_align_flt,
    input logic             o_ovf_flt
);
    // R6: a misaligned wide fetch yields no slots
    p_align_noslot_r6: assert property (@(posedge clk) disable iff (rst)
        o_align_flt |-> (o_slot_vld == '0));

    // R2: valid slots always form a prefix from slot 0
    p_slot_prefix_r2: assert property (@(posedge clk) disable iff (rst)
        (((o_slot_vld + 1'b1) & o_slot_vld) == '0));

    // R3: sequential modes mark every valid slot as a bundle end
    p_seq_eob_r3: assert property (@(posedge clk) disable iff (rst)
        (o_vld && !o_mode[1]) |-> ((o_slot_eob | ~o_slot_vld) == '1));

    // R5: illegal flags only appear in RISC-V wide mode
    p_ill_rvwide_r5: assert property (@(posedge clk) disable iff (rst)
        (o_vld && (o_mode != 2'b11)) |-> (o_slot_ill == '0));

    // R7: overflow only in a wide mode
    p_ovf_wide_r7: assert property (@(posedge clk) disable iff (rst)
        o_ovf_flt |-> o_mode[1]);

    // R8: odd redirect target flips the ISA bit
    p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (i_redir && i_redir_bit0 && !i_sr_wr) |=> (o_mode[0] != $past(o_mode[0])));

    // R8: redirect drops the same-cycle fetch
    p_redir_drop_r8: assert property (@(posedge clk) disable iff (rst)
        i_redir |=> !o_vld);

    // R9: mode write loads the mode
    p_mode_write_r9: assert property (@(posedge clk) disable iff (rst)
        i_sr_wr |=> (o_mode == $past(i_sr_mode)));
endmodule

bind dmi_dec dmi_dec_chk #(.NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .i_redir     (i_redir),
    .i_redir_bit0(i_redir_tgt[0]),
    .i_sr_wr     (i_sr_wr),
    .i_sr_mode   (i_sr_mode),
    .o_mode      (o_mode),
    .o_vld       (o_vld),
    .o_slot_vld  (o_slot_vld),
    .o_slot_eob  (o_slot_eob),
    .o_slot_ill  (o_slot_ill),
    .o_align_flt (o_align_flt),
    .o_ovf_flt   (o_ovf_flt)
);

// File: tb/dmi_dec_tb.sv
module dmi_dec_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_fetch_vld = 1'b0;
    logic [31:0] i_fetch_addr = '0;
    logic [63:0] i_fetch_win = '0;
    logic        i_redir = 1'b0;
    logic [31:0] i_redir_tgt = '0;
    logic        i_sr_wr = 1'b0;
    logic [1:0]  i_sr_mode = '0;
    logic [1:0]  o_mode;
    logic        o_vld;
    logic [3:0]  o_slot_vld, o_slot_len32, o_slot_eob, o_slot_ill;
    logic        o_align_flt, o_ovf_flt;
    logic [31:0] o_next_addr;

    int ncmp = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    dmi_dec u_dut (
        .clk(clk), .rst(rst),
        .i_fetch_vld(i_fetch_vld), .i_fetch_addr(i_fetch_addr), .i_fetch_win(i_fetch_win),
        .i_redir(i_redir), .i_redir_tgt(i_redir_tgt),
        .i_sr_wr(i_sr_wr), .i_sr_mode(i_sr_mode),
        .o_mode(o_mode), .o_vld(o_vld),
        .o_slot_vld(o_slot_vld), .o_slot_len32(o_slot_len32),
        .o_slot_eob(o_slot_eob), .o_slot_ill(o_slot_ill),
        .o_align_flt(o_align_flt), .o_ovf_flt(o_ovf_flt),
        .o_next_addr(o_next_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        ncmp++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic fv, input logic [31:0] a, input logic [63:0] w,
                         input logic rv, input logic [31:0] t,
                         input logic sw, input logic [1:0] sm);
        @(negedge clk);
        i_fetch_vld = fv; i_fetch_addr = a; i_fetch_win = w;
        i_redir = rv; i_redir_tgt = t; i_sr_wr = sw; i_sr_mode = sm;
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic [31:0] a, input logic [63:0] w);
        drive(1'b1, a, w, 1'b0, '0, 1'b0, 2'b00);
    endtask

    task automatic set_mode(input logic [1:0] m);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, m);
    endtask

    function automatic logic [63:0] w2(input logic [1:0] lo0, input logic [1:0] lo1);
        return {30'h0, lo1, 30'h0, lo0};
    endfunction

    task automatic t_reset();
        chk("R1 mode", o_mode, 2'b00);
        chk("R1 vld", o_vld, 1'b0);
        chk("R1 slots", {o_slot_vld, o_slot_len32, o_slot_eob, o_slot_ill}, 16'h0);
        chk("R1 flags", {o_align_flt, o_ovf_flt}, 2'b00);
        chk("R1 next", o_next_addr, 32'h0);
    endtask

    task automatic t_native_seq();
        fetch(32'h100, w2(2'b01, 2'b10));
        chk("R11 vld", {o_vld, o_slot_vld}, 5'b1_0011);
        chk("R11 len", o_slot_len32, 4'b0011);
        chk("R3 eob", o_slot_eob, 4'b0011);
        chk("R10 next", o_next_addr, 32'h108);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b0, 2'b00);
        chk("R10 one-cycle vld", o_vld, 1'b0);
        chk("R10 next hold", o_next_addr, 32'h108);
    endtask

    task automatic t_native_wide();
        set_mode(2'b10);
        chk("R9 mode", o_mode, 2'b10);
        fetch(32'h200, w2(2'b10, 2'b11));
        chk("R11 wide vld", o_slot_vld, 4'b0011);
        chk("R11 wide eob", o_slot_eob, 4'b0010);
        chk("R11 wide next", o_next_addr, 32'h208);
    endtask

    task automatic t_rv_scalar();
        set_mode(2'b01);
        fetch(32'h300, {16'h0002, 16'h0000, 16'h0003, 16'h0001});
        chk("R2 mix vld", o_slot_vld, 4'b0111);
        chk("R2 mix len", o_slot_len32, 4'b0010);
        chk("R3 scalar eob", o_slot_eob, 4'b0111);
        chk("R2 mix next", o_next_addr, 32'h308);
        fetch(32'h402, {16'h0003, 16'h0002, 16'h0000, 16'h0000});
        chk("R2 split vld", {o_align_flt, o_slot_vld}, 5'b0_0111);
        chk("R2 split len", o_slot_len32, 4'b0000);
        chk("R2 split next", o_next_addr, 32'h408);
        fetch(32'h500, {16'h0001, 16'h0000, 16'h0000, 16'h001F});
        chk("R2 long vld", o_slot_vld, 4'b0111);
        chk("R2 long len", o_slot_len32, 4'b0001);
        fetch(32'h600, 64'h0002_0001_0000_0002);
        chk("R2 packed vld", o_slot_vld, 4'b1111);
        chk("R2 packed len", o_slot_len32, 4'b0000);
        chk("R2 packed next", o_next_addr, 32'h608);
    endtask

    task automatic t_rv_wide();
        set_mode(2'b11);
        fetch(32'h700, w2(2'b10, 2'b11));
        chk("R4 vld", o_slot_vld, 4'b0011);
        chk("R4 len", o_slot_len32, 4'b0011);
        chk("R4 eob", o_slot_eob, 4'b0010);
        chk("R4 ill", o_slot_ill, 4'b0000);
        fetch(32'h708, w2(2'b00, 2'b01));
        chk("R5 ill", o_slot_ill, 4'b0011);
        chk("R5 eob", o_slot_eob, 4'b0011);
        chk("R5 vld", o_slot_vld, 4'b0011);
        fetch(32'h712, w2(2'b11, 2'b11));
        chk("R6 align", o_align_flt, 1'b1);
        chk("R6 vld", o_slot_vld, 4'b0000);
        chk("R6 next", o_next_addr, 32'h712);
    endtask

    task automatic t_overflow();
        set_mode(2'b11);
        fetch(32'h800, w2(2'b10, 2'b10));
        chk("R7 first eob", {o_ovf_flt, o_slot_eob}, 5'b0_0000);
        fetch(32'h808, w2(2'b10, 2'b10));
        chk("R7 forced eob", o_slot_eob, 4'b0001);
        chk("R7 ovf", o_ovf_flt, 1'b1);
        fetch(32'h810, w2(2'b11, 2'b11));
        chk("R7 clean", {o_ovf_flt, o_slot_eob}, 5'b0_0011);
    endtask

    task automatic t_redirect();
        fetch(32'h900, w2(2'b11, 2'b10));
        chk("R4 open", o_slot_eob, 4'b0001);
        drive(1'b1, 32'h980, w2(2'b10, 2'b10), 1'b1, 32'h4001, 1'b0, 2'b00);
        chk("R8 drop", o_vld, 1'b0);
        chk("R8 toggle", o_mode, 2'b10);
        chk("R8 target", o_next_addr, 32'h4000);
        fetch(32'h4000, w2(2'b10, 2'b10));
        chk("R8 bundle cleared", {o_ovf_flt, o_slot_eob}, 5'b0_0000);
        drive(1'b0, '0, '0, 1'b1, 32'h5000, 1'b0, 2'b00);
        chk("R8 even keeps", o_mode, 2'b10);
        chk("R8 even target", o_next_addr, 32'h5000);
        drive(1'b0, '0, '0, 1'b1, 32'h6001, 1'b0, 2'b00);
        chk("R8 back", o_mode, 2'b11);
    endtask

    task automatic t_priority();
        drive(1'b1, 32'hA00, w2(2'b11, 2'b11), 1'b1, 32'h7001, 1'b1, 2'b01);
        chk("R9 write wins", o_mode, 2'b01);
        chk("R9 drop", o_vld, 1'b0);
        chk("R8 target", o_next_addr, 32'h7000);
    endtask

    initial begin
        #(CLK_P * 100000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_native_seq();
        t_native_wide();
        t_rv_scalar();
        t_rv_wide();
        t_overflow();
        t_redirect();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end
endmodule